// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block drives a two-wire serial bus as its only master. A host writes byte-wide registers to control it. A command register accepts two fixed codes: one opens a transaction with a START condition and the other closes it with a STOP condition. Opening a transaction also sends the byte already placed in the data register. Every data-register write after that, while the engine holds the bus between bytes, sends one more byte.

Each byte goes out most-significant bit first. A bit takes four quarter periods: two with SCL low, then two with SCL high. SDA moves one quarter after SCL falls. When acknowledge clocking is on, a ninth clock follows with SDA released, and the level on the line is stored as the received acknowledge bit. The engine detects START and STOP conditions on the bus lines and reports them through a bus-busy flag. It gives a one-cycle pulse when a byte finishes. A rate bit sets the quarter period to either the full parameterised count or a quarter of it, which gives the two standard bus speeds from one system clock.

Writes use a 2-bit register index: 0 is data, 1 is command, 2 is control, 3 is clock setup.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o and sda_o are 1, bus_busy is 0, ack_rx is 1 and byte_done is 0.
- R2: Writing 0xF0 to index 1 starts a transaction, but only when the engine is enabled, idle and bus_busy is 0. The START takes three quarters: SCL and SDA both high, then SDA low with SCL high, then both low.
- R3: After the START, the byte in index 0 goes out MSB first. Each bit has four quarters with scl_o pattern 0,0,1,1. sda_o keeps the previous bit during the first quarter and takes the new bit at the second quarter, so it never changes while SCL is high.
- R4: When bit 7 of index 3 is 1, a ninth clock cell follows each byte with sda_o at 1. ack_rx takes the SDA line level from the last cycle of that cell's first high quarter.
- R5: When bit 7 of index 3 is 0, a byte has only eight clock cells and ack_rx keeps its value.
- R6: Between bytes the engine holds scl_o low. A write to index 0 in that state loads the byte and sends it at once.
- R7: Writing 0xD0 to index 1 while holding the bus produces a STOP: SDA low with SCL low, then SCL high, then SDA high. The engine then returns to idle with both lines high.
- R8: bus_busy goes to 1 one cycle after the SDA line falls while SCL stays high. It goes to 0 one cycle after the SDA line rises while SCL stays high.
- R9: byte_done is 1 for exactly one cycle: the first cycle with SCL low after a byte's last clock cell.
- R10: A quarter lasts STD_QUARTER clock cycles when bit 5 of index 3 is 0, and STD_QUARTER/4 cycles when it is 1.
- R11: Bit 3 of index 2 enables the engine. While it is 0, commands and byte launches are ignored, although data writes in idle or hold still load the byte.
- R12: These writes are ignored: command values other than 0xF0 and 0xD0 (0x00 included), any command or data write while a sequence is running, 0xF0 while holding the bus, and 0xD0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 data, 1 command, 2 control, 3 clock setup |
| wr_data | input | 8 | Write data |
| sda_i | input | 1 | SDA level driven by the slave (1 when released) |
| scl_o | output | 1 | Serial clock driven by the master |
| sda_o | output | 1 | Serial data driven by the master (1 = released) |
| bus_busy | output | 1 | 1 from a START on the bus until a STOP |
| ack_rx | output | 1 | Last sampled acknowledge level (0 = acknowledged) |
| byte_done | output | 1 | One-cycle pulse at the end of each byte |

## Verification
The assertions assume the slave pulls sda_i low only during the acknowledge cell and never stretches the clock. Under those conditions, any SDA edge while SCL is high belongs to START or STOP. They also assume the clock setup register stays unchanged while a byte is being sent. The bench keeps to these limits: it drives sda_i low only in the acknowledge quarters its model schedules, and it changes the rate and acknowledge bits only while the bus is idle or held. It still sends commands and data in the middle of a byte to confirm that they are ignored.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int STD_QUARTER = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       bus_busy,
  output logic       ack_rx,
  output logic       byte_done
);
  localparam int FAST_QUARTER = (STD_QUARTER / 4 > 0) ? STD_QUARTER / 4 : 1;
  localparam int CW = $clog2(STD_QUARTER + 1);
  localparam logic [7:0] CMD_OPEN  = 8'hF0;
  localparam logic [7:0] CMD_CLOSE = 8'hD0;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_XFER, S_STOP} st_t;

  st_t st;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [CW-1:0] cnt;
  logic [7:0] sh;
  logic en, ackclk, fast;
  logic sda_r, ack_r, busy_r, done_r, scl_q, sda_q;

  wire tick     = (cnt == '0);
  wire [CW-1:0] reload = fast ? CW'(FAST_QUARTER - 1) : CW'(STD_QUARTER - 1);
  wire wr_dat   = wr_en && (wr_addr == 2'd0);
  wire wr_cmd   = wr_en && (wr_addr == 2'd1);
  wire go_start = wr_cmd && wr_data == CMD_OPEN  && en && st == S_IDLE && !busy_r;
  wire go_stop  = wr_cmd && wr_data == CMD_CLOSE && en && st == S_HOLD;
  wire go_byte  = wr_dat && en && st == S_HOLD;
  wire last     = (bitn == (ackclk ? 4'd8 : 4'd7));
  wire sda_line = sda_o & sda_i;
  wire xfer_on  = (st == S_XFER);

  assign scl_o = (st == S_IDLE) | (st == S_START && q != 2'd2) |
                 (xfer_on && q[1]) | (st == S_STOP && q != 2'd0);
  assign sda_o     = sda_r;
  assign bus_busy  = busy_r;
  assign ack_rx    = ack_r;
  assign byte_done = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bitn <= '0; cnt <= '0; sh <= '0;
      en <= 1'b0; ackclk <= 1'b0; fast <= 1'b0;
      sda_r <= 1'b1; ack_r <= 1'b1; busy_r <= 1'b0; done_r <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      done_r <= 1'b0;
      scl_q  <= scl_o;
      sda_q  <= sda_line;
      if (scl_q && scl_o && sda_q && !sda_line) busy_r <= 1'b1;
      else if (scl_q && scl_o && !sda_q && sda_line) busy_r <= 1'b0;

      if (wr_en && wr_addr == 2'd2) en <= wr_data[3];
      if (wr_en && wr_addr == 2'd3) begin
        ackclk <= wr_data[7];
        fast   <= wr_data[5];
      end
      if (wr_dat && (st == S_IDLE || st == S_HOLD)) sh <= wr_data;

      case (st)
        S_IDLE: if (go_start) begin
          st <= S_START; q <= '0; cnt <= reload;
        end
        S_HOLD: if (go_byte) begin
          st <= S_XFER; q <= '0; bitn <= '0; cnt <= reload;
        end else if (go_stop) begin
          st <= S_STOP; q <= '0; cnt <= reload; sda_r <= 1'b0;
        end
        S_START: if (tick) begin
          cnt <= reload;
          if (q == 2'd2) begin
            st <= S_XFER; q <= '0; bitn <= '0;
          end else begin
            q <= q + 2'd1;
            if (q == 2'd0) sda_r <= 1'b0;
          end
        end else cnt <= cnt - 1'b1;
        S_XFER: if (tick) begin
          cnt <= reload;
          q   <= q + 2'd1;
          case (q)
            2'd0: sda_r <= (bitn == 4'd8) ? 1'b1 : sh[7];
            2'd2: if (bitn == 4'd8) ack_r <= sda_line;
            2'd3: if (last) begin
              st <= S_HOLD; done_r <= 1'b1;
            end else begin
              bitn <= bitn + 4'd1;
              sh   <= {sh[6:0], 1'b0};
            end
            default: ;
          endcase
        end else cnt <= cnt - 1'b1;
        S_STOP: if (tick) begin
          cnt <= reload;
          if (q == 2'd2) st <= S_IDLE;
          else begin
            q <= q + 2'd1;
            if (q == 2'd1) sda_r <= 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_i,
  input logic scl_o,
  input logic sda_o,
  input logic bus_busy,
  input logic ack_rx,
  input logic byte_done,
  input logic xfer_on
);
  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_on && scl_o && $past(scl_o)) |-> $stable(sda_o));

  // R4
  ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_rx) |-> ($past(scl_o) && $past(xfer_on)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> ($past(scl_o) && !$past(sda_o & sda_i)));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> ($past(scl_o) && $past(sda_o & sda_i)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R9
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !scl_o);
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
  .bus_busy(bus_busy), .ack_rx(ack_rx), .byte_done(byte_done), .xfer_on(xfer_on)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  localparam int SQ = 8;
  localparam int FQ = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, sda_i = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic scl_o, sda_o, bus_busy, ack_rx, byte_done;

  i2c_byte_master #(.STD_QUARTER(SQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .bus_busy(bus_busy),
    .ack_rx(ack_rx), .byte_done(byte_done)
  );

  typedef struct packed {logic scl; logic sda; logic sdai; logic smp; logic done;} ent_t;
  ent_t exq[$];
  ent_t rest = '{scl:1'b1, sda:1'b1, sdai:1'b1, smp:1'b0, done:1'b0};

  int vec = 0, bad = 0;
  string cur_req = "R1";
  bit m_en = 0, m_ack = 0, m_fast = 0, m_held = 0, m_sda = 1;
  logic [7:0] m_sh = '0;
  bit e_busy = 0, e_ack = 1, p_scl = 1, p_line = 1;

  task automatic chk(string r, string what, logic act, logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int qn();
    return m_fast ? FQ : SQ;
  endfunction

  task automatic push_q(logic scl, logic sda, logic sdai, bit smp);
    for (int k = 0; k < qn(); k++)
      exq.push_back('{scl:scl, sda:sda, sdai:sdai, smp:(smp && k == qn() - 1), done:1'b0});
  endtask

  task automatic push_byte(logic ackv);
    logic prev, b;
    prev = m_sda;
    for (int i = 7; i >= 0; i--) begin
      b = m_sh[i];
      push_q(0, prev, 1, 0); push_q(0, b, 1, 0); push_q(1, b, 1, 0); push_q(1, b, 1, 0);
      prev = b;
    end
    if (m_ack) begin
      push_q(0, prev, 1, 0); push_q(0, 1, ackv, 0); push_q(1, 1, ackv, 1); push_q(1, 1, ackv, 0);
      prev = 1;
    end
    m_sda = prev;
    exq.push_back('{scl:1'b0, sda:prev, sdai:1'b1, smp:1'b0, done:1'b1});
    rest = '{scl:1'b0, sda:prev, sdai:1'b1, smp:1'b0, done:1'b0};
  endtask

  task automatic cycle();
    ent_t c;
    logic line;
    @(negedge clk);
    c = (exq.size() > 0) ? exq.pop_front() : rest;
    sda_i = c.sdai;
    chk(cur_req, "scl_o", scl_o, c.scl);
    chk(cur_req, "sda_o", sda_o, c.sda);
    chk("R9", "byte_done", byte_done, c.done);
    chk("R8", "bus_busy", bus_busy, e_busy);
    chk("R4", "ack_rx", ack_rx, e_ack);
    line = c.sda & c.sdai;
    if (p_scl && c.scl && p_line && !line) e_busy = 1;
    else if (p_scl && c.scl && !p_line && line) e_busy = 0;
    p_scl = c.scl; p_line = line;
    if (c.smp) e_ack = c.sdai;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic ackv = 1'b1);
    bit free;
    free = (exq.size() == 0);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      2'd0: if (free) begin
        m_sh = d;
        if (m_held && m_en) push_byte(ackv);
      end
      2'd1: if (free && m_en) begin
        if (d == 8'hF0 && !m_held && !e_busy) begin
          push_q(1, 1, 1, 0); push_q(1, 0, 1, 0); push_q(0, 0, 1, 0);
          m_held = 1; m_sda = 0;
          push_byte(ackv);
        end else if (d == 8'hD0 && m_held) begin
          push_q(0, 0, 1, 0); push_q(1, 0, 1, 0); push_q(1, 1, 1, 0);
          m_held = 0; m_sda = 1;
          rest = '{scl:1'b1, sda:1'b1, sdai:1'b1, smp:1'b0, done:1'b0};
        end
      end
      2'd2: m_en = d[3];
      default: begin m_ack = d[7]; m_fast = d[5]; end
    endcase
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (exq.size() > 0) cycle();
    cycle();
    cycle();
  endtask

  task automatic idle_for(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    @(negedge clk);
    chk("R1", "scl_o reset", scl_o, 1'b1);
    chk("R1", "sda_o reset", sda_o, 1'b1);
    chk("R1", "bus_busy reset", bus_busy, 1'b0);
    chk("R1", "ack_rx reset", ack_rx, 1'b1);
    chk("R1", "byte_done reset", byte_done, 1'b0);
    idle_for(3);

    wr(2'd3, 8'h85);
    cur_req = "R11";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hA6);
    wr(2'd1, 8'hF0);
    idle_for(40);

    wr(2'd2, 8'h08);
    cur_req = "R12";
    wr(2'd1, 8'h00);
    wr(2'd1, 8'hD0);
    idle_for(10);

    cur_req = "R2";
    wr(2'd1, 8'hF0, 1'b0);
    cur_req = "R3";
    drain();

    cur_req = "R12";
    wr(2'd1, 8'hF0);
    idle_for(10);

    cur_req = "R6";
    wr(2'd0, 8'h3C, 1'b1);
    drain();

    cur_req = "R12";
    wr(2'd0, 8'h55, 1'b0);
    idle_for(13);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hFF);
    idle_for(21);
    wr(2'd1, 8'hF0);
    drain();

    cur_req = "R11";
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h99);
    idle_for(20);
    wr(2'd2, 8'h08);

    cur_req = "R7";
    wr(2'd1, 8'hD0);
    drain();

    cur_req = "R10";
    wr(2'd3, 8'h25);
    wr(2'd0, 8'hC3);
    wr(2'd1, 8'hF0);
    drain();
    cur_req = "R5";
    wr(2'd0, 8'h81);
    drain();
    cur_req = "R7";
    wr(2'd1, 8'hD0);
    drain();

    cur_req = "R4";
    wr(2'd3, 8'hA5);
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hF0, 1'b0);
    drain();
    wr(2'd0, 8'hF0, 1'b1);
    drain();
    wr(2'd1, 8'hD0);
    drain();
    idle_for(5);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule